// File: doc/BRIEF.md
# Memory Access Monitor with Interrupt

This block observes the traffic on three memory regions (on-chip RAM, data tightly-coupled memory and instruction tightly-coupled memory). Each region reports one access per cycle as valid, write, byte address and an allocated flag. The allocated flag says whether the address falls in a bank that is assigned to that region.

The monitor raises two kinds of event for each region. An error event occurs when a valid access targets an unallocated address. A match event occurs when an access of the selected direction falls inside the 8-byte word named by that region's watch register. An event is recorded in a sticky status flag only if its bit is set in a status-enable mask. Software clears a flag by writing 1 to it. A separate signal-enable mask selects which recorded flags drive one level-sensitive interrupt line.

Software uses a word-indexed register bus with a one-cycle read latency. Read data and a read-valid strobe are registered.

Top module: `mem_access_monitor`

## Requirements
- R1: Status flag positions are: bit0 on-chip RAM error, bit1 data TCM error, bit2 instruction TCM error, bit3 on-chip RAM match, bit4 data TCM match, bit5 instruction TCM match. Status bits 31:6 read as zero.
- R2: A valid access with the allocated flag low sets that region's error flag at the next clock edge, if the flag is enabled. A valid access with the allocated flag high sets no error flag.
- R3: A region's watch register holds byte address bits [15:3] in its bits [12:0]. A match requires equality of access address bits [15:3], so any byte of the same 8-byte word matches and the next word does not.
- R4: The watch register bit 16 selects direction: 0 lets only reads match, 1 lets only writes match.
- R5: Writing to the status register (word index 0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: The status-enable register (word index 1, bits 5:0) gates latching. An event whose enable bit is 0 leaves its status bit at 0.
- R7: The interrupt is high one cycle after any status bit and the matching signal-enable bit (word index 2, bits 5:0) are both 1. It falls one cycle after that condition ends.
- R8: If an event and a clear of the same bit happen in the same cycle, the bit stays set.
- R9: After synchronous reset, status, both enable registers, the watch registers and the interrupt are zero.
- R10: Watch registers sit at word indices 3, 4 and 5 for on-chip RAM, data TCM and instruction TCM. Each register and both enable registers read back what was written, with unused bits as zero. Read data appears with the read-valid strobe one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 3 | Per-region access valid (0 on-chip RAM, 1 data TCM, 2 instruction TCM) |
| acc_write | input | 3 | Per-region access is a write |
| acc_addr | input | 48 | Per-region byte address, 16 bits each, region 0 in the low bits |
| acc_alloc | input | 3 | Per-region address is allocated |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Level interrupt |

## Verification
The bench places accesses at the last byte of a watched word and at the first byte of the next word. A design that compares too many or too few address bits would then miss a match or report a false one. It issues a match-direction access of the wrong kind, which a design that ignored the direction bit would latch. It also issues a clear in the same cycle as a new event on that bit, where a design that gave the clear priority would lose the event. Writes of 0 to the status register, and events masked by the status-enable register, are checked by reading status back, which catches any toggle or ungated latch.

// File: rtl/mam_pkg.sv
package mam_pkg;
  localparam int NUM_REGIONS = 3;
  localparam int NUM_FLAGS   = 2 * NUM_REGIONS;
  localparam int BUS_AW      = 4;
  localparam int BUS_DW      = 32;
  localparam int WORD_SHIFT  = 3;
  localparam int DIR_BIT     = 16;

  localparam logic [BUS_AW-1:0] IDX_STATUS = 4'd0;
  localparam logic [BUS_AW-1:0] IDX_STATEN = 4'd1;
  localparam logic [BUS_AW-1:0] IDX_SIGEN  = 4'd2;
  localparam logic [BUS_AW-1:0] IDX_WATCH0 = 4'd3;

  typedef enum logic { DIR_READ = 1'b0, DIR_WRITE = 1'b1 } watch_dir_e;
endpackage

// File: rtl/mam_region_detect.sv
module mam_region_detect #(
  parameter int ADDR_W = 16,
  parameter int SHIFT  = 3,
  localparam int WA_W  = ADDR_W - SHIFT
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              alloc,
  input  logic [WA_W-1:0]   watch_addr,
  input  logic              watch_dir,
  output logic              err_evt,
  output logic              match_evt
);
  logic dir_ok;
  logic addr_ok;

  always_comb begin
    dir_ok    = (write == watch_dir);
    addr_ok   = (addr[ADDR_W-1:SHIFT] == watch_addr);
    err_evt   = valid && !alloc;
    match_evt = valid && dir_ok && addr_ok;
  end
endmodule

// File: rtl/mam_status.sv
module mam_status #(
  parameter int NFLAGS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAGS-1:0] events,
  input  logic [NFLAGS-1:0] stat_en,
  input  logic [NFLAGS-1:0] sig_en,
  input  logic [NFLAGS-1:0] clr_mask,
  output logic [NFLAGS-1:0] status_q,
  output logic              irq_q
);
  logic [NFLAGS-1:0] gated;
  logic [NFLAGS-1:0] status_d;

  always_comb begin
    gated    = events & stat_en;
    // a fresh event overrides a same-cycle clear
    status_d = (status_q & ~clr_mask) | gated;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |(status_q & sig_en);
    end
  end
endmodule

// File: rtl/mam_regfile.sv
module mam_regfile
  import mam_pkg::*;
#(
  parameter int NREG   = 3,
  parameter int NFLAGS = 6,
  parameter int WA_W   = 13,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic                      re,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  input  logic [NFLAGS-1:0]         status,
  output logic [NFLAGS-1:0]         stat_en_q,
  output logic [NFLAGS-1:0]         sig_en_q,
  output logic [NREG-1:0][WA_W-1:0] watch_addr_q,
  output logic [NREG-1:0]           watch_dir_q,
  output logic [NFLAGS-1:0]         clr_mask,
  output logic [DW-1:0]             rdata_q,
  output logic                      rvalid_q
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    clr_mask = (we && addr == IDX_STATUS) ? wdata[NFLAGS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_en_q <= '0;
      sig_en_q  <= '0;
    end else if (we) begin
      if (addr == IDX_STATEN) stat_en_q <= wdata[NFLAGS-1:0];
      if (addr == IDX_SIGEN)  sig_en_q  <= wdata[NFLAGS-1:0];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_watch
    localparam logic [AW-1:0] MY_IDX = AW'(int'(IDX_WATCH0) + g);
    always_ff @(posedge clk) begin
      if (rst) begin
        watch_addr_q[g] <= '0;
        watch_dir_q[g]  <= 1'b0;
      end else if (we && addr == MY_IDX) begin
        watch_addr_q[g] <= wdata[WA_W-1:0];
        watch_dir_q[g]  <= wdata[DIR_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == IDX_STATUS) rd_mux[NFLAGS-1:0] = status;
    if (addr == IDX_STATEN) rd_mux[NFLAGS-1:0] = stat_en_q;
    if (addr == IDX_SIGEN)  rd_mux[NFLAGS-1:0] = sig_en_q;
    for (int i = 0; i < NREG; i++) begin
      if (addr == AW'(int'(IDX_WATCH0) + i)) begin
        rd_mux[WA_W-1:0] = watch_addr_q[i];
        rd_mux[DIR_BIT]  = watch_dir_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re;
      if (re) rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/mem_access_monitor.sv
module mem_access_monitor
  import mam_pkg::*;
#(
  parameter int NREG   = NUM_REGIONS,
  parameter int ADDR_W = 16,
  localparam int NFLAGS = 2 * NREG,
  localparam int WA_W   = ADDR_W - WORD_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREG-1:0]        acc_valid,
  input  logic [NREG-1:0]        acc_write,
  input  logic [NREG*ADDR_W-1:0] acc_addr,
  input  logic [NREG-1:0]        acc_alloc,
  input  logic                   bus_we,
  input  logic                   bus_re,
  input  logic [BUS_AW-1:0]      bus_addr,
  input  logic [BUS_DW-1:0]      bus_wdata,
  output logic [BUS_DW-1:0]      bus_rdata,
  output logic                   bus_rvalid,
  output logic                   irq
);
  logic [NFLAGS-1:0]         status_q;
  logic [NFLAGS-1:0]         stat_en_q;
  logic [NFLAGS-1:0]         sig_en_q;
  logic [NFLAGS-1:0]         clr_mask;
  logic [NREG-1:0][WA_W-1:0] watch_addr_q;
  logic [NREG-1:0]           watch_dir_q;
  logic [NREG-1:0]           err_evt;
  logic [NREG-1:0]           match_evt;
  logic [NFLAGS-1:0]         events;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    mam_region_detect #(.ADDR_W(ADDR_W), .SHIFT(WORD_SHIFT)) u_det (
      .valid      (acc_valid[g]),
      .write      (acc_write[g]),
      .addr       (acc_addr[g*ADDR_W +: ADDR_W]),
      .alloc      (acc_alloc[g]),
      .watch_addr (watch_addr_q[g]),
      .watch_dir  (watch_dir_q[g]),
      .err_evt    (err_evt[g]),
      .match_evt  (match_evt[g])
    );
  end

  assign events = {match_evt, err_evt};

  mam_regfile #(.NREG(NREG), .NFLAGS(NFLAGS), .WA_W(WA_W),
                .AW(BUS_AW), .DW(BUS_DW)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .we           (bus_we),
    .re           (bus_re),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .status       (status_q),
    .stat_en_q    (stat_en_q),
    .sig_en_q     (sig_en_q),
    .watch_addr_q (watch_addr_q),
    .watch_dir_q  (watch_dir_q),
    .clr_mask     (clr_mask),
    .rdata_q      (bus_rdata),
    .rvalid_q     (bus_rvalid)
  );

  mam_status #(.NFLAGS(NFLAGS)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .events   (events),
    .stat_en  (stat_en_q),
    .sig_en   (sig_en_q),
    .clr_mask (clr_mask),
    .status_q (status_q),
    .irq_q    (irq)
  );
endmodule

// File: rtl/mam_checker.sv
module mam_checker #(
  parameter int ADDR_W = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    acc_valid,
  input logic [2:0]    acc_write,
  input logic [3*ADDR_W-1:0] acc_addr,
  input logic [2:0]    acc_alloc,
  input logic          bus_we,
  input logic          bus_re,
  input logic [3:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          irq,
  input logic [5:0]    status_q,
  input logic [5:0]    stat_en_q,
  input logic [5:0]    sig_en_q,
  input logic [2:0][ADDR_W-4:0] watch_addr_q,
  input logic [2:0]    watch_dir_q
);
  AST_ERR_OCRAM_SETS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid[0] && !acc_alloc[0] && stat_en_q[0]) |=> status_q[0]); // R2

  AST_ALLOC_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (!status_q[1] && !(acc_valid[1] && !acc_alloc[1])) |=> !status_q[1]); // R2

  AST_MATCH_DTCM_SETS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid[1] && stat_en_q[4] && (acc_write[1] == watch_dir_q[1]) &&
     (acc_addr[ADDR_W+3 +: ADDR_W-3] == watch_addr_q[1])) |=> status_q[4]); // R3

  AST_WRONG_DIR_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!status_q[5] && (acc_write[2] != watch_dir_q[2])) |=> !status_q[5]); // R4

  AST_MASKED_STAYS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!status_q[3] && !stat_en_q[3]) |=> !status_q[3]); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'd0 && bus_wdata[0] && !(acc_valid[0] && !acc_alloc[0]))
    |=> !status_q[0]); // R5

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(status_q != 6'd0)); // R7

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == 4'd0) |=> (bus_rdata[31:6] == 26'd0)); // R1

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'd0 && bus_wdata[2] && acc_valid[2] && !acc_alloc[2] && stat_en_q[2])
    |=> status_q[2]); // R8
endmodule

bind mem_access_monitor mam_checker #(.ADDR_W(ADDR_W)) u_mam_checker (
  .clk          (clk),
  .rst          (rst),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_addr     (acc_addr),
  .acc_alloc    (acc_alloc),
  .bus_we       (bus_we),
  .bus_re       (bus_re),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .irq          (irq),
  .status_q     (status_q),
  .stat_en_q    (stat_en_q),
  .sig_en_q     (sig_en_q),
  .watch_addr_q (watch_addr_q),
  .watch_dir_q  (watch_dir_q)
);

// File: tb/test_mem_access_monitor.sv
module test_mem_access_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  acc_valid = '0;
  logic [2:0]  acc_write = '0;
  logic [47:0] acc_addr = '0;
  logic [2:0]  acc_alloc = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mem_access_monitor i_mem_access_monitor (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_alloc(acc_alloc), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq));

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s read: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    @(negedge clk);
  endtask

  task automatic access(input int r, input logic w, input logic [15:0] a, input logic al);
    @(negedge clk);
    acc_valid[r] = 1'b1; acc_write[r] = w; acc_addr[r*16 +: 16] = a; acc_alloc[r] = al;
    @(negedge clk);
    acc_valid = '0;
  endtask

  task automatic check_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq: actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset values
    check_irq(1'b0, "R9");
    rd(4'd0, 32'h0, "R9 status");
    rd(4'd1, 32'h0, "R9 stat_en");
    rd(4'd2, 32'h0, "R9 sig_en");
    rd(4'd4, 32'h0, "R9 watch1");
    // R10 register read-back
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h3F, "R10 stat_en");
    wr(4'd3, 32'h0001_0100);  // OCRAM watch 0x0800, write
    wr(4'd4, 32'h0001_0247);  // DTCM  watch 0x1238, write
    wr(4'd5, 32'h0000_0400);  // ITCM  watch 0x2000, read
    rd(4'd4, 32'h0001_0247, "R10 watch1");
    rd(4'd5, 32'h0000_0400, "R10 watch2");
    // R2 error on unallocated access
    access(0, 1'b0, 16'h0100, 1'b0);
    rd(4'd0, 32'h01, "R2 ocram error");
    access(1, 1'b0, 16'h0100, 1'b1);
    rd(4'd0, 32'h01, "R2 allocated no error");
    // R3 granularity
    access(1, 1'b1, 16'h123F, 1'b1);
    rd(4'd0, 32'h11, "R3 last byte of word");
    wr(4'd0, 32'h10);
    access(1, 1'b1, 16'h1240, 1'b1);
    rd(4'd0, 32'h01, "R3 next word no match");
    // R4 direction
    access(1, 1'b0, 16'h1238, 1'b1);
    rd(4'd0, 32'h01, "R4 read ignored on write watch");
    access(2, 1'b1, 16'h2004, 1'b1);
    rd(4'd0, 32'h01, "R4 write ignored on read watch");
    access(2, 1'b0, 16'h2004, 1'b1);
    rd(4'd0, 32'h21, "R4 read matches R1 bit5");
    // R5 clear semantics
    wr(4'd0, 32'h0);
    rd(4'd0, 32'h21, "R5 write zero no effect");
    wr(4'd0, 32'h20);
    rd(4'd0, 32'h01, "R5 write one clears");
    // R6 status-enable gating
    wr(4'd1, 32'h37);         // bit3 disabled
    access(0, 1'b1, 16'h0805, 1'b1);
    rd(4'd0, 32'h01, "R6 masked match");
    // R7 interrupt
    check_irq(1'b0, "R7 no sig_en");
    wr(4'd2, 32'h02);
    check_irq(1'b0, "R7 unrelated bit");
    access(1, 1'b0, 16'h0010, 1'b0);   // DTCM error -> bit1
    @(negedge clk);
    check_irq(1'b1, "R7 raised");
    wr(4'd0, 32'h02);
    @(negedge clk);
    check_irq(1'b0, "R7 dropped");
    // R8 event vs clear
    @(negedge clk);
    acc_valid[2] = 1'b1; acc_write[2] = 1'b0; acc_addr[47:32] = 16'h0; acc_alloc[2] = 1'b0;
    bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h04;
    @(negedge clk);
    acc_valid = '0; bus_we = 1'b0;
    rd(4'd0, 32'h05, "R8 event wins");
    // R9 reset again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(4'd0, 32'h0, "R9 status after reset");
    rd(4'd3, 32'h0, "R9 watch0 after reset");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 reads missing: actual %0d outstanding expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule